// File: doc/BRIEF.md
# Two-Read One-Write Register File with Same-Cycle Bypass

This block holds the general-purpose registers of a pipelined processor core. The decode stage uses its two read ports to fetch both source operands every cycle. The write-back stage uses the single write port to commit one result per cycle. Both read ports are combinational: the data for an address is on the output in the same cycle the address is presented. The write port updates storage on the rising clock edge.

A result that retires in a given cycle must reach an operand fetch of the same register in that same cycle. The block behaves as though the write lands in the first half of the cycle and the reads sample in the second half. It achieves this without a second clock phase, using a bypass path from the write port to each read port. Register 0 is a constant zero: writes to it are dropped and it is never bypassed. A synchronous, active-high reset clears every register.

Top module: `regfile_2r1w`

## Requirements
- R1: In the first cycle after a synchronous reset (`rst` high at a rising edge), every address from 0 to 31 reads as zero on both ports unless it is being written that cycle.
- R2: Address 0 reads as all zeros on both ports in every cycle, whatever has been written.
- R3: A write to address 0 with `wr_en` high changes nothing: it is not bypassed in that cycle and address 0 still reads zero afterwards.
- R4: With `wr_en` high and a nonzero `wr_addr`, the rising edge replaces all `DATA_W` bits of that register with `wr_data`, and later reads of it return that word.
- R5: When `wr_en` is high, `wr_addr` is nonzero and a read port's address equals `wr_addr`, that port returns `wr_data` combinationally in the same cycle.
- R6: When both read ports name the register being written, both return `wr_data` in that cycle.
- R7: With `wr_en` low, no register changes and reads return the stored contents, whatever `wr_addr` and `wr_data` carry.
- R8: The two read ports are independent, so different addresses on port A and port B each return their own register's contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 5 | Register written when `wr_en` is high |
| wr_data | input | DATA_W (32) | Word to store |
| rd_a_addr | input | 5 | Read port A address |
| rd_a_data | output | DATA_W (32) | Read port A data, combinational |
| rd_b_addr | input | 5 | Read port B address |
| rd_b_data | output | DATA_W (32) | Read port B data, combinational |

## Verification
The properties assume that all inputs carry known values whenever reset is low. They also assume the read addresses are stable for the whole cycle, so a combinational read value is settled when the rising edge samples it. The properties that look back one cycle also rely on reset lasting at least one full edge. The stimulus drives every input on the falling edge, so nothing changes near the sampling edge. It holds reset through several edges before releasing it, and it never drives X or Z once reset is released.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int RF_DEF_DATA_W   = 32;
    localparam int RF_DEF_NUM_REGS = 32;

    // Where a read port takes its data from.
    typedef enum logic [1:0] {
        RD_SRC_ZERO   = 2'd0,
        RD_SRC_BYPASS = 2'd1,
        RD_SRC_ARRAY  = 2'd2
    } rd_src_e;

    // The zero register wins over the bypass; the bypass wins over storage.
    function automatic rd_src_e pick_source(input logic addr_is_zero,
                                            input logic write_hit);
        if (addr_is_zero)
            return RD_SRC_ZERO;
        else if (write_hit)
            return RD_SRC_BYPASS;
        else
            return RD_SRC_ARRAY;
    endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 5
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [NUM_REGS-1:0] wr_sel
);

    // One strobe per register; entry 0 never receives one.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        if (i == 0) begin : g_zero
            assign wr_sel[i] = 1'b0;
        end else begin : g_live
            assign wr_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
        end
    end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_REGS-1:0]              wr_sel,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  word_q
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        if (i == 0) begin : g_const
            // Register 0 has no flops at all.
            assign word_q[i] = '0;
        end else begin : g_flop
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wr_sel[i])
                    q <= wr_data;
            end
            assign word_q[i] = q;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  word_q,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_data
);

    logic              addr_zero;
    logic              write_hit;
    rd_src_e           src;
    logic [DATA_W-1:0] array_word;

    assign addr_zero = (rd_addr == '0);
    assign write_hit = wr_en && (wr_addr == rd_addr);
    assign src       = pick_source(addr_zero, write_hit);

    always_comb begin
        array_word = '0;
        if (int'(rd_addr) < NUM_REGS)
            array_word = word_q[rd_addr];
    end

    always_comb begin
        unique case (src)
            RD_SRC_ZERO:   rd_data = '0;
            RD_SRC_BYPASS: rd_data = wr_data;
            RD_SRC_ARRAY:  rd_data = array_word;
            default:       rd_data = '0;
        endcase
    end

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
    import rf_pkg::*;
#(
    parameter int DATA_W   = RF_DEF_DATA_W,
    parameter int NUM_REGS = RF_DEF_NUM_REGS,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);

    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:0]             wr_sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] word_q;
    logic [NUM_RD-1:0][ADDR_W-1:0]   rd_addr_v;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data_v;

    assign rd_addr_v[0] = rd_a_addr;
    assign rd_addr_v[1] = rd_b_addr;
    assign rd_a_data    = rd_data_v[0];
    assign rd_b_data    = rd_data_v[1];

    rf_write_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_sel  (wr_sel)
    );

    rf_storage #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .word_q  (word_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port #(
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS),
            .ADDR_W   (ADDR_W)
        ) u_port (
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .word_q  (word_q),
            .rd_addr (rd_addr_v[p]),
            .rd_data (rd_data_v[p])
        );
    end

endmodule

// File: rtl/regfile_2r1w_chk.sv
module regfile_2r1w_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_a_addr,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [ADDR_W-1:0] rd_b_addr,
    input logic [DATA_W-1:0] rd_b_data
);

    logic hit_a, hit_b;
    assign hit_a = wr_en && (wr_addr != '0) && (wr_addr == rd_a_addr);
    assign hit_b = wr_en && (wr_addr != '0) && (wr_addr == rd_b_addr);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !hit_a) |-> (rd_a_data == '0));

    // R2
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    // R2
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    // R3
    zero_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == '0 && rd_b_addr == '0) |-> (rd_b_data == '0));

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_addr) != '0 &&
         rd_a_addr == $past(wr_addr) && !hit_a) |-> (rd_a_data == $past(wr_data)));

    // R5
    bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
        hit_a |-> (rd_a_data == wr_data));

    // R6
    bypass_both_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_a && hit_b) |-> (rd_a_data == wr_data && rd_b_data == wr_data));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && !wr_en &&
         rd_b_addr == $past(rd_b_addr)) |-> $stable(rd_b_data));

endmodule

bind regfile_2r1w regfile_2r1w_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data)
);

// File: tb/regfile_2r1w_tb.sv
`timescale 1ns/1ps
module regfile_2r1w_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_a_addr = '0;
    logic [31:0] rd_a_data;
    logic [4:0]  rd_b_addr = '0;
    logic [31:0] rd_b_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] mdl [32];

    always #2 clk = ~clk;   // 250 MHz

    regfile_2r1w u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_a_addr (rd_a_addr),
        .rd_a_data (rd_a_data),
        .rd_b_addr (rd_b_addr),
        .rd_b_data (rd_b_data)
    );

    function automatic logic [31:0] expect_rd(input logic [4:0] ra);
        if (ra == 5'd0)
            return 32'h0;
        if (wr_en && wr_addr == ra)
            return wr_data;
        return mdl[ra];
    endfunction

    task automatic compare(input string req, input logic [31:0] got, input logic [31:0] exp_v,
                           input string port);
        checks++;
        if (got !== exp_v) begin
            errors++;
            $display("FAIL %s port %s: got %h expected %h", req, port, got, exp_v);
        end
    endtask

    // One cycle: drive on the falling edge, check settled reads, then the model commits.
    task automatic step(input string req, input logic we, input logic [4:0] wa,
                        input logic [31:0] wd, input logic [4:0] ra, input logic [4:0] rb);
        @(negedge clk);
        rst = 1'b0;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        #1;
        compare(req, rd_a_data, expect_rd(ra), "A");
        compare(req, rd_b_data, expect_rd(rb), "B");
        if (we && wa != 5'd0)
            mdl[wa] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd4; wr_data = 32'hDEAD_0004;
        repeat (3) @(posedge clk);
        for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
        do_reset();

        // R1: everything reads zero after reset
        for (int i = 0; i < 32; i++)
            step("R1", 1'b0, 5'(i), 32'hFFFF_FFFF, 5'(i), 5'(31 - i));

        // R4: fill every register with a distinct full-width word
        for (int i = 1; i < 32; i++)
            step("R4", 1'b1, 5'(i), {8'(i), ~8'(i), 8'hA5, 8'(i * 7)}, 5'd0, 5'd0);
        step("R4", 1'b1, 5'd30, 32'hFFFF_FFFF, 5'd30, 5'd1);
        step("R4", 1'b1, 5'd31, 32'h5555_AAAA, 5'd30, 5'd31);
        step("R4", 1'b0, 5'd0, 32'h0, 5'd31, 5'd30);

        // R8: two different registers per cycle
        for (int i = 0; i < 32; i++)
            step("R8", 1'b0, 5'd0, 32'h0, 5'(i), 5'((i + 13) % 32));

        // R3: writes to register 0 vanish, even in the same cycle
        step("R3", 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
        step("R3", 1'b1, 5'd0, 32'h1234_5678, 5'd0, 5'd2);
        // R2: address 0 still zero afterwards
        step("R2", 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);

        // R5: same-cycle bypass on one port, the other reads storage
        step("R5", 1'b1, 5'd5, 32'hCAFE_0005, 5'd5, 5'd7);
        step("R5", 1'b1, 5'd7, 32'hBEEF_0007, 5'd5, 5'd7);
        step("R5", 1'b0, 5'd0, 32'h0, 5'd7, 5'd5);

        // R6: both ports hit the register being written
        step("R6", 1'b1, 5'd9, 32'h0909_F00D, 5'd9, 5'd9);
        step("R6", 1'b0, 5'd9, 32'h0, 5'd9, 5'd9);

        // R7: write enable low with live-looking address and data
        step("R7", 1'b0, 5'd3, 32'h7777_7777, 5'd3, 5'd3);
        step("R7", 1'b0, 5'd3, 32'h8888_8888, 5'd3, 5'd4);
        step("R7", 1'b0, 5'd0, 32'h0, 5'd3, 5'd4);

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++)
            step("R4", 1'($urandom), 5'($urandom), $urandom, 5'($urandom), 5'($urandom));
        for (int n = 0; n < 500; n++) begin
            automatic logic [4:0] a = 5'($urandom % 4);
            step("R5", 1'b1, a, $urandom, a, 5'($urandom % 4));
        end

        // R1: reset in the middle of a run
        do_reset();
        for (int i = 0; i < 32; i++)
            step("R1", 1'b0, 5'd0, 32'h0, 5'(i), 5'(i));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule